// File: doc/BRIEF.md
# SPI Master Port

This block is a synchronous serial port that acts as an SPI master behind a 32-bit register bus. Software sets a frame length, a clock divider and a clock mode, then enables the port. Each word it writes to the data register is queued and shifted out most significant bit first. The word clocked in at the same time lands in a receive queue, where software reads it back through the same data register.

A status word shows how full each queue is and raises flags for "receive data present" and "transmit space free". One level-sensitive interrupt line combines three sources, and each source has its own enable: the transmit queue running low, the receive queue filling up, and received data that has sat unread for too long. The select line follows the shifter on its own. Software can instead take the line over and drive its level directly.

Top module: `spi_port_host`

## Requirements
- R1: Register at byte offset 0x00 holds the clock divider field in bits [19:8], the port enable in bit 7 and the frame-size field in bits [3:0]. Every other bit reads as zero, and the written fields read back unchanged.
- R2: Register at offset 0x04 holds these fields and reads them back: timeout interrupt enable at bit 19, receive threshold field at [13:10], transmit threshold field at [9:6], clock phase at bit 4, clock polarity at bit 3, transmit interrupt enable at bit 1, receive interrupt enable at bit 0.
- R3: Status at offset 0x08 reads as follows. Bits [15:12] give the receive level and bits [11:8] the transmit level, each capped at 15. Bit 3 is set when the receive queue is not empty. Bit 2 is set when the transmit queue is not full. All other bits are zero, so an idle, drained port reads 0x0000_0004.
- R4: While the enable bit is clear, a write to the data register at offset 0x10 is dropped and the transmit level stays 0.
- R5: A frame carries (frame-size field + 1) bits, most significant bit first on the data-out line. Each transmitted frame produces exactly one received frame. A read of the data register returns the oldest received frame in its low bits and removes it from the queue.
- R6: The clock idles at the polarity bit. With phase 0, input is sampled on the first clock edge of each bit. With phase 1, input is sampled on the second edge. Output data changes only at bit boundaries.
- R7: One serial clock period lasts (divider field + 1) system clocks. A field of 0 is treated as a period of 2.
- R8: Each queue holds 16 frames. Data written while the transmit queue is full is dropped. A full transmit queue reads back a level of 15 with the not-full flag clear.
- R9: The transmit interrupt, when enabled, is high while the transmit level is at most (transmit threshold field + 1).
- R10: The receive interrupt, when enabled, is high while the receive level is at least (receive threshold field + 1).
- R11: The timeout interrupt, when enabled, rises once received data has gone 64 serial clock periods with no push into and no pop from the receive queue. A data-register read clears it.
- R12: Clearing the enable bit empties both queues, aborts any frame in flight, returns the clock to its idle polarity and holds the interrupt line low.
- R13: Select register at offset 0x18: bit 0 picks software control, and bit 1 is then the level of the active-low select output. With bit 0 clear, the select output is low while a frame is shifting or data is queued with the port enabled, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| irq | output | 1 | Combined level interrupt |

## Verification
The shifter is swept over all four clock modes, four dividers (including the field value 0 that is clamped to a period of 2) and three frame lengths (5, 8 and 16 bits). A model of the remote device answers each frame with a different word on the input line. This sweep separates bit-order faults from phase faults: a port that samples on the wrong edge returns the response shifted by one bit, and a wrong divider shows up as a wrong gap between sampling edges. A very slow divider is used to fill the transmit queue past its depth, which exercises level saturation, dropped writes, the transmit threshold on each side of its boundary, and the flush on disable. A short run with unread receive data then checks the receive threshold at its boundary and the timeout on each side of its 64-period limit.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int FRAME_MAX   = 16;
    localparam int FSZ_W       = $clog2(FRAME_MAX);
    localparam int DIV_W       = 12;
    localparam int THR_W       = 4;
    localparam int LVL_FIELD_W = 4;
    localparam int CNT_W       = DIV_W + 1;
    localparam int ADDR_W      = 6;

    localparam logic [ADDR_W-1:0] OFS_MAIN = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CSEL = 6'h18;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             en;
        logic [FSZ_W-1:0] fsz;
    } main_cfg_t;

    typedef struct packed {
        logic             ie_to;
        logic [THR_W-1:0] rx_thr;
        logic [THR_W-1:0] tx_thr;
        logic             cpha;
        logic             cpol;
        logic             ie_tx;
        logic             ie_rx;
    } aux_cfg_t;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    // Serial clock period in system clocks, never below two.
    function automatic logic [CNT_W-1:0] eff_period(input logic [DIV_W-1:0] field);
        logic [CNT_W-1:0] n;
        n = {1'b0, field} + 1'b1;
        return (n < CNT_W'(2)) ? CNT_W'(2) : n;
    endfunction

    // Queue level shown in a 4-bit status field.
    function automatic logic [LVL_FIELD_W-1:0] sat_level(input logic [15:0] lvl);
        return (lvl > 16'd15) ? 4'hF : lvl[LVL_FIELD_W-1:0];
    endfunction

endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign level   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_FIFO_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LW'(DEPTH) && push && !pop && !flush) |=> (cnt_q == LW'(DEPTH))); // R8

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
    import spi_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div_field,
    input  logic [FSZ_W-1:0]     fsz,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic [FRAME_MAX-1:0] tx_data,
    input  logic                 tx_empty,
    input  logic                 rx_full,
    input  logic                 miso,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic [FRAME_MAX-1:0] rx_data,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 busy
);
    eng_state_t           state_q;
    logic [CNT_W-1:0]     cyc_q;
    logic [FSZ_W-1:0]     bits_left_q;
    logic [FRAME_MAX-1:0] out_sh_q, in_sh_q;
    logic [CNT_W-1:0]     period, first_len;
    logic                 in_first, at_sample, at_end;

    assign period    = eff_period(div_field);
    assign first_len = period - (period >> 1);
    assign in_first  = (cyc_q < first_len);
    assign at_sample = (state_q == ENG_SHIFT) && (cyc_q == first_len - 1'b1);
    assign at_end    = (state_q == ENG_SHIFT) && (cyc_q == period - 1'b1);

    assign tx_pop  = (state_q == ENG_IDLE) && en && !tx_empty && !rx_full;
    assign rx_push = at_end && (bits_left_q == '0);
    assign rx_data = in_sh_q;
    assign busy    = (state_q == ENG_SHIFT);
    assign mosi    = busy ? out_sh_q[FRAME_MAX-1] : 1'b0;
    // Phase 0: idle level in the first half of a bit; phase 1: active level first.
    assign sclk    = busy ? (cpol ^ (cpha ? in_first : !in_first)) : cpol;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q     <= ENG_IDLE;
            cyc_q       <= '0;
            bits_left_q <= '0;
            out_sh_q    <= '0;
            in_sh_q     <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (tx_pop) begin
                        state_q     <= ENG_SHIFT;
                        cyc_q       <= '0;
                        bits_left_q <= fsz;
                        out_sh_q    <= tx_data << (FSZ_W'(FRAME_MAX - 1) - fsz);
                        in_sh_q     <= '0;
                    end
                end
                default: begin
                    if (at_sample) in_sh_q <= {in_sh_q[FRAME_MAX-2:0], miso};
                    if (at_end) begin
                        cyc_q <= '0;
                        if (bits_left_q == '0) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            bits_left_q <= bits_left_q - 1'b1;
                            out_sh_q    <= out_sh_q << 1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_IDLE) |-> (sclk == cpol)); // R6
    AST_MOSI_HELD_IN_BIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_SHIFT && cyc_q != '0) |-> $stable(mosi)); // R6
    AST_POP_ONLY_WHEN_ROOM: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (!tx_empty && !rx_full && en)); // R5

endmodule

// File: rtl/spi_port_irq.sv
module spi_port_irq
    import spi_port_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TO_PERIODS = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [DIV_W-1:0]           div_field,
    input  aux_cfg_t                   cfg,
    input  logic [$clog2(DEPTH+1)-1:0] tx_level,
    input  logic [$clog2(DEPTH+1)-1:0] rx_level,
    input  logic                       rx_push,
    input  logic                       rx_pop,
    output logic                       irq
);
    localparam int TOW = CNT_W + $clog2(TO_PERIODS) + 1;

    logic [THR_W:0]   tx_n, rx_n;
    logic [TOW-1:0]   limit, to_cnt_q;
    logic             to_flag_q, tx_hit, rx_hit;

    assign tx_n   = {1'b0, cfg.tx_thr} + 1'b1;
    assign rx_n   = {1'b0, cfg.rx_thr} + 1'b1;
    assign tx_hit = int'(tx_level) <= int'(tx_n);
    assign rx_hit = int'(rx_level) >= int'(rx_n);
    assign limit  = TOW'(eff_period(div_field)) * TOW'(TO_PERIODS);

    always_ff @(posedge clk) begin
        if (rst || !en || rx_push || rx_pop || rx_level == '0) begin
            to_cnt_q  <= '0;
            to_flag_q <= 1'b0;
        end else if (to_cnt_q == limit) begin
            to_flag_q <= 1'b1;
        end else begin
            to_cnt_q <= to_cnt_q + 1'b1;
        end
    end

    assign irq = en && ((cfg.ie_tx && tx_hit) ||
                        (cfg.ie_rx && rx_hit) ||
                        (cfg.ie_to && to_flag_q));

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> en); // R12
    AST_TIMEOUT_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> !to_flag_q); // R11

endmodule

// File: rtl/spi_port_host.sv
module spi_port_host
    import spi_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_PERIODS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              irq
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    main_cfg_t            main_q;
    aux_cfg_t             aux_q;
    logic [1:0]           csel_q;
    logic                 wr_acc, rd_acc;
    logic                 tx_push, tx_pop, rx_push, rx_pop;
    logic [FRAME_MAX-1:0] tx_head, rx_head, rx_frame;
    logic [LW-1:0]        tx_lvl, rx_lvl;
    logic                 tx_empty, tx_full, rx_empty, rx_full;
    logic                 busy;
    logic                 unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:20], bus_wdata[18:14], bus_wdata[5], bus_wdata[2]};

    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign tx_push = wr_acc && (bus_addr == OFS_DATA) && main_q.en;
    assign rx_pop  = rd_acc && (bus_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            aux_q  <= '0;
            csel_q <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                OFS_MAIN: main_q <= '{div: bus_wdata[19:8], en: bus_wdata[7], fsz: bus_wdata[3:0]};
                OFS_AUX:  aux_q  <= '{ie_to: bus_wdata[19], rx_thr: bus_wdata[13:10],
                                      tx_thr: bus_wdata[9:6], cpha: bus_wdata[4], cpol: bus_wdata[3],
                                      ie_tx: bus_wdata[1], ie_rx: bus_wdata[0]};
                OFS_CSEL: csel_q <= bus_wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MAIN: begin
                bus_rdata[19:8] = main_q.div;
                bus_rdata[7]    = main_q.en;
                bus_rdata[3:0]  = main_q.fsz;
            end
            OFS_AUX: begin
                bus_rdata[19]    = aux_q.ie_to;
                bus_rdata[13:10] = aux_q.rx_thr;
                bus_rdata[9:6]   = aux_q.tx_thr;
                bus_rdata[4]     = aux_q.cpha;
                bus_rdata[3]     = aux_q.cpol;
                bus_rdata[1]     = aux_q.ie_tx;
                bus_rdata[0]     = aux_q.ie_rx;
            end
            OFS_STAT: begin
                bus_rdata[15:12] = sat_level(16'(rx_lvl));
                bus_rdata[11:8]  = sat_level(16'(tx_lvl));
                bus_rdata[3]     = !rx_empty;
                bus_rdata[2]     = !tx_full;
            end
            OFS_DATA: bus_rdata[FRAME_MAX-1:0] = rx_empty ? '0 : rx_head;
            OFS_CSEL: bus_rdata[1:0] = csel_q;
            default:  bus_rdata = '0;
        endcase
    end

    spi_port_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst(rst), .flush(!main_q.en), .push(tx_push), .pop(tx_pop),
        .din(bus_wdata[FRAME_MAX-1:0]), .dout(tx_head), .level(tx_lvl),
        .empty(tx_empty), .full(tx_full));

    spi_port_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst(rst), .flush(!main_q.en), .push(rx_push), .pop(rx_pop),
        .din(rx_frame), .dout(rx_head), .level(rx_lvl),
        .empty(rx_empty), .full(rx_full));

    spi_port_shifter shifter_i (
        .clk(clk), .rst(rst), .en(main_q.en), .div_field(main_q.div), .fsz(main_q.fsz),
        .cpol(aux_q.cpol), .cpha(aux_q.cpha), .tx_data(tx_head), .tx_empty(tx_empty),
        .rx_full(rx_full), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_frame), .sclk(sclk), .mosi(mosi), .busy(busy));

    spi_port_irq #(.DEPTH(FIFO_DEPTH), .TO_PERIODS(TO_PERIODS)) irq_i (
        .clk(clk), .rst(rst), .en(main_q.en), .div_field(main_q.div), .cfg(aux_q),
        .tx_level(tx_lvl), .rx_level(rx_lvl), .rx_push(rx_push), .rx_pop(rx_pop), .irq(irq));

    assign cs_n = csel_q[0] ? csel_q[1] : !(busy || (main_q.en && !tx_empty));

    AST_SOFT_SELECT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        csel_q[0] |-> (cs_n == csel_q[1])); // R13
    AST_DISABLED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && bus_addr == OFS_DATA && !main_q.en) |=> (tx_lvl == '0)); // R4
    AST_RX_NEVER_OVER: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full); // R5

endmodule

// File: tb/spi_port_host_tb.sv
`timescale 1ns/1ps
module spi_port_host_tb_top;
    import spi_port_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, cs_n, irq;

    always #4 clk = ~clk;

    spi_port_host dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .irq(irq));

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fmask(input int b);
        return 16'((32'h1 << b) - 1);
    endfunction

    // Remote device model
    bit          mon_on = 0, cur_cpol = 0, cur_cpha = 0, cur_hwcs = 1;
    int          cur_bits = 8, cur_n = 2, mon_k = 0, mon_idx = 0;
    logic [15:0] tx_exp [64];
    logic [15:0] rsp [64];
    logic [15:0] mon_cap = '0;
    realtime     last_t = 0;

    always_comb miso = mon_on ? rsp[mon_idx & 63][cur_bits - 1 - mon_k] : 1'b0;

    always @(sclk) begin
        if (mon_on && sclk === (cur_cpol ^ ~cur_cpha)) begin
            if (cur_hwcs) chk("R13 select low in frame", cs_n, 0);
            if (mon_k > 0) chk("R7 sample spacing", int'(($realtime - last_t) / 8.0), cur_n);
            last_t  = $realtime;
            mon_cap = {mon_cap[14:0], mosi};
            mon_k++;
            if (mon_k == cur_bits) begin
                chk("R5 R6 mosi frame", mon_cap & fmask(cur_bits),
                    tx_exp[mon_idx & 63] & fmask(cur_bits));
                mon_k = 0;
                mon_idx++;
            end
        end
    end

    task automatic bwr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic cfg(input int div, input int fs, input logic [31:0] aux);
        bwr(OFS_MAIN, 32'((div << 8) | fs));
        bwr(OFS_AUX, aux);
        bwr(OFS_MAIN, 32'((div << 8) | 32'h80 | fs));
    endtask

    task automatic wait_rx(input int n);
        logic [31:0] s;
        bit ok = 0;
        for (int it = 0; it < 4000 && !ok; it++) begin
            brd(OFS_STAT, s);
            if (int'(s[15:12]) == n && s[11:8] == 4'h0) ok = 1;
            else repeat (4) @(negedge clk);
        end
        chk("R5 frames completed", ok, 1);
    endtask

    task automatic run_combo(input int seed, input int div, input int fs, input bit pol, input bit pha);
        logic [31:0] d;
        cur_bits = fs + 1;
        cur_n    = (div == 0) ? 2 : div + 1;
        cur_cpol = pol;
        cur_cpha = pha;
        cur_hwcs = 1;
        for (int i = 0; i < 4; i++) begin
            tx_exp[i] = 16'(seed * 7919 + i * 4099 + 32'h1234);
            rsp[i]    = 16'(seed * 31337 + i * 2731) ^ 16'h5A96;
        end
        mon_idx = 0;
        mon_k   = 0;
        cfg(div, fs, 32'((pha << 4) | (pol << 3)));
        brd(OFS_MAIN, d);
        chk("R1 main readback", d, (div << 8) | 32'h80 | fs);
        chk("R6 idle clock level", sclk, pol);
        mon_on = 1;
        for (int i = 0; i < 4; i++) bwr(OFS_DATA, {16'h0, tx_exp[i]});
        wait_rx(4);
        mon_on = 0;
        chk("R5 one rx per tx", mon_idx, 4);
        for (int i = 0; i < 4; i++) begin
            brd(OFS_DATA, d);
            chk("R5 rx word", d, 32'(rsp[i] & fmask(cur_bits)));
        end
        brd(OFS_STAT, d);
        chk("R3 drained status", d, 32'h4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int seed;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // Reset state
        brd(OFS_STAT, d);  chk("R3 reset status", d, 32'h4);
        brd(OFS_MAIN, d);  chk("R1 reset main", d, 0);
        chk("R13 reset select", cs_n, 1);
        chk("R6 reset clock", sclk, 0);
        chk("R12 reset irq", irq, 0);

        // Writes while disabled
        for (int i = 0; i < 3; i++) bwr(OFS_DATA, 32'hAB00 + i);
        brd(OFS_STAT, d);  chk("R4 disabled writes dropped", d, 32'h4);

        // Software select
        bwr(OFS_CSEL, 32'h1);  chk("R13 soft low", cs_n, 0);
        brd(OFS_CSEL, d);      chk("R13 select readback", d, 1);
        bwr(OFS_CSEL, 32'h3);  chk("R13 soft high", cs_n, 1);
        bwr(OFS_CSEL, 32'h0);  chk("R13 auto idle", cs_n, 1);

        // Sweep modes, dividers, frame sizes
        seed = 0;
        for (int m = 0; m < 4; m++)
            for (int di = 0; di < 4; di++)
                for (int fi = 0; fi < 3; fi++) begin
                    run_combo(seed, (di == 3) ? 4 : di, (fi == 0) ? 7 : (fi == 1) ? 4 : 15,
                              m[1], m[0]);
                    seed++;
                end

        // Queue fill with slow clock and transmit threshold
        cfg(4095, 7, 32'((15 << 6) | (1 << 3) | 2));
        chk("R9 tx irq empty queue", irq, 1);
        for (int i = 0; i < 20; i++) bwr(OFS_DATA, 32'h40 + i);
        brd(OFS_STAT, d);  chk("R8 full status", d, 32'h0F00);
        chk("R9 tx irq at level 16 thr 16", irq, 1);
        chk("R13 auto select low busy", cs_n, 0);
        bwr(OFS_AUX, 32'((14 << 6) | (1 << 3) | 2));
        chk("R9 tx irq level 16 thr 15", irq, 0);
        bwr(OFS_AUX, 32'((15 << 6) | (1 << 3) | 2));
        bwr(OFS_MAIN, 32'((4095 << 8) | 7));
        brd(OFS_STAT, d);  chk("R12 flushed status", d, 32'h4);
        chk("R12 clock parked", sclk, 1);
        chk("R12 irq off when disabled", irq, 0);
        chk("R13 select released", cs_n, 1);

        // Receive threshold and timeout
        cur_bits = 8; cur_n = 2; cur_cpol = 0; cur_cpha = 0; cur_hwcs = 1;
        for (int i = 0; i < 3; i++) begin
            tx_exp[i] = 16'(8'h31 + i * 8'h17);
            rsp[i]    = 16'(8'hC4 - i * 8'h29);
        end
        mon_idx = 0; mon_k = 0;
        cfg(1, 7, 32'((2 << 10) | 1));
        brd(OFS_AUX, d);   chk("R2 aux readback", d, 32'((2 << 10) | 1));
        mon_on = 1;
        for (int i = 0; i < 3; i++) bwr(OFS_DATA, {16'h0, tx_exp[i]});
        wait_rx(3);
        mon_on = 0;
        chk("R10 rx irq at level 3 thr 3", irq, 1);
        brd(OFS_DATA, d);  chk("R5 rx word", d, 32'(rsp[0] & 16'hFF));
        chk("R10 rx irq level 2 thr 3", irq, 0);
        bwr(OFS_AUX, 32'h80000 | 32'(5 << 10) | 32'(7 << 6) | 32'h1B);
        brd(OFS_AUX, d);   chk("R2 aux full readback", d, 32'h80000 | 32'(5 << 10) | 32'(7 << 6) | 32'h1B);
        bwr(OFS_AUX, 32'h80000);
        repeat (85) @(negedge clk);
        chk("R11 no timeout before limit", irq, 0);
        repeat (45) @(negedge clk);
        chk("R11 timeout after limit", irq, 1);
        brd(OFS_DATA, d);  chk("R5 rx word", d, 32'(rsp[1] & 16'hFF));
        chk("R11 read clears timeout", irq, 0);
        bwr(OFS_MAIN, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule